// File: doc/BRIEF.md
# Relative branch decode unit

This unit sits in the decode stage of a byte-addressed 8-bit microcontroller core. Each cycle it looks at the 16-bit instruction word in decode, the program counter of that instruction and the four status flags: negative, overflow, zero and carry. From these it decides whether the word is a relative branch, and whether that branch is taken. It then gives the program counter to fetch next. One encoding branches unconditionally. Eight encodings branch on one flag being set or being clear.

Branch offsets count instruction words, while the program counter counts bytes. The unit therefore sign-extends the offset and doubles it before adding it to the address of the following instruction. A taken branch makes the word fetched behind it invalid. The unit raises a stall for one cycle so that this word is flushed. The flushed word is never treated as a branch, whatever its encoding. The unit never writes the status flags.

Top module: `rbr_unit`

## Requirements
- R1: A word whose bits [15:11] are 11010 is an unconditional branch with an 11-bit two's-complement word offset in bits [10:0] (range -1024..+1023). It is always taken unless it is flushed.
- R2: A word whose bits [15:11] are 11100 is a conditional branch with an 8-bit two's-complement word offset in bits [7:0] (range -128..+127). Bits [10:9] select the flag: 0 = zero, 1 = carry, 2 = overflow, 3 = negative. Bit [8] = 0 branches when that flag is 1, and bit [8] = 1 branches when it is 0. When the condition holds, the branch is taken.
- R3: For a taken branch, next_pc_o equals the aligned pc_i plus 2 plus twice the sign-extended word offset.
- R4: A conditional branch whose condition fails gives taken_o = 0 and next_pc_o = aligned pc_i + 2. It causes no stall.
- R5: Any word that matches neither encoding gives taken_o = 0 and next_pc_o = aligned pc_i + 2. It causes no stall.
- R6: stall_o is high in the cycle that follows a cycle with taken_o = 1, and only then. It therefore lasts exactly one cycle per taken branch.
- R7: While stall_o is high, the word in decode is flushed: taken_o = 0 and next_pc_o = aligned pc_i + 2, even when the word is a branch whose condition holds. A flushed word causes no stall.
- R8: Bit 0 of pc_i is ignored, and bit 0 of next_pc_o is always 0.
- R9: While rst_ni is low, stall_o is 0.
- R10: All program-counter arithmetic wraps modulo 2^21, both forward past the top address and backward below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word in decode |
| pc_i | input | 21 | Byte address of the instruction in decode |
| flag_n_i | input | 1 | Negative flag |
| flag_ov_i | input | 1 | Overflow flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| taken_o | output | 1 | Branch taken this cycle |
| next_pc_o | output | 21 | Byte address to fetch next |
| stall_o | output | 1 | Bubble request; flushes the word in decode |

## Verification
A bubble and a new branch decision can fall in the same cycle. This happens when the word fetched behind a taken branch is itself a branch whose condition holds. The bench provokes it with back-to-back unconditional branches and with a met conditional branch placed right after a taken one. It expects taken_o low, the sequential address and no second stall, and a branch placed after the bubble must then be taken normally. Its reference model carries only the expected stall bit from one cycle to the next, and it compares all three outputs on every clock.

// File: rtl/rbr_pkg.sv
package rbr_pkg;
  localparam logic [4:0] UNC_OP = 5'b11010;
  localparam logic [4:0] CND_OP = 5'b11100;

  typedef enum logic [1:0] {
    FLG_Z  = 2'd0,
    FLG_C  = 2'd1,
    FLG_OV = 2'd2,
    FLG_N  = 2'd3
  } flag_sel_e;

  typedef struct packed {
    logic      is_uncond;
    logic      is_cond;
    flag_sel_e flag;
    logic      on_clear;
  } br_kind_t;
endpackage

// File: rtl/rbr_decode.sv
module rbr_decode
  import rbr_pkg::*;
#(
  parameter int INSTR_W   = 16,
  parameter int UNC_OFF_W = 11,
  parameter int CND_OFF_W = 8,
  parameter int OFF_W     = 12
) (
  input  logic [INSTR_W-1:0]    instr_i,
  output br_kind_t              kind_o,
  output logic signed [OFF_W-1:0] woff_o
);
  localparam int OP_W = 5;

  logic [OP_W-1:0] op;
  assign op = instr_i[INSTR_W-1 -: OP_W];

  always_comb begin
    kind_o.is_uncond = (op == UNC_OP);
    kind_o.is_cond   = (op == CND_OP);
    kind_o.flag      = flag_sel_e'(instr_i[CND_OFF_W+2 -: 2]);
    kind_o.on_clear  = instr_i[CND_OFF_W];
    if (kind_o.is_uncond)
      woff_o = {{(OFF_W-UNC_OFF_W){instr_i[UNC_OFF_W-1]}}, instr_i[UNC_OFF_W-1:0]};
    else if (kind_o.is_cond)
      woff_o = {{(OFF_W-CND_OFF_W){instr_i[CND_OFF_W-1]}}, instr_i[CND_OFF_W-1:0]};
    else
      woff_o = '0;
  end
endmodule

// File: rtl/rbr_cond_eval.sv
module rbr_cond_eval
  import rbr_pkg::*;
(
  input  br_kind_t kind_i,
  input  logic     flag_n_i,
  input  logic     flag_ov_i,
  input  logic     flag_z_i,
  input  logic     flag_c_i,
  output logic     hit_o
);
  logic sel;

  always_comb begin
    unique case (kind_i.flag)
      FLG_Z:   sel = flag_z_i;
      FLG_C:   sel = flag_c_i;
      FLG_OV:  sel = flag_ov_i;
      default: sel = flag_n_i;
    endcase
  end

  assign hit_o = kind_i.is_uncond | (kind_i.is_cond & (sel ^ kind_i.on_clear));
endmodule

// File: rtl/rbr_target.sv
module rbr_target #(
  parameter int PC_W  = 21,
  parameter int OFF_W = 12
) (
  input  logic [PC_W-1:0]         pc_i,
  input  logic signed [OFF_W-1:0] woff_i,
  output logic [PC_W-1:0]         seq_pc_o,
  output logic [PC_W-1:0]         tgt_pc_o
);
  localparam int EXT_W = PC_W - OFF_W - 1;

  logic [PC_W-1:0] pc_al;
  logic [PC_W-1:0] disp;

  // word offset -> byte displacement, sign-extended to PC width
  assign pc_al    = pc_i & ~PC_W'(1);
  assign disp     = {{EXT_W{woff_i[OFF_W-1]}}, woff_i, 1'b0};
  assign seq_pc_o = pc_al + PC_W'(2);
  assign tgt_pc_o = seq_pc_o + disp;
endmodule

// File: rtl/rbr_unit.sv
module rbr_unit
  import rbr_pkg::*;
#(
  parameter int INSTR_W   = 16,
  parameter int PC_W      = 21,
  parameter int UNC_OFF_W = 11,
  parameter int CND_OFF_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic               flag_n_i,
  input  logic               flag_ov_i,
  input  logic               flag_z_i,
  input  logic               flag_c_i,
  output logic               taken_o,
  output logic [PC_W-1:0]    next_pc_o,
  output logic               stall_o
);
  localparam int OFF_W = UNC_OFF_W + 1;

  br_kind_t                kind;
  logic signed [OFF_W-1:0] woff;
  logic                    hit;
  logic [PC_W-1:0]         seq_pc, tgt_pc;
  logic                    stall_q;

  rbr_decode #(
    .INSTR_W(INSTR_W), .UNC_OFF_W(UNC_OFF_W), .CND_OFF_W(CND_OFF_W), .OFF_W(OFF_W)
  ) u_decode (
    .instr_i(instr_i), .kind_o(kind), .woff_o(woff)
  );

  rbr_cond_eval u_cond (
    .kind_i(kind), .flag_n_i(flag_n_i), .flag_ov_i(flag_ov_i),
    .flag_z_i(flag_z_i), .flag_c_i(flag_c_i), .hit_o(hit)
  );

  rbr_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
    .pc_i(pc_i), .woff_i(woff), .seq_pc_o(seq_pc), .tgt_pc_o(tgt_pc)
  );

  // word in decode during the bubble is the stale fetch: never a branch
  assign taken_o   = hit & ~stall_q;
  assign next_pc_o = taken_o ? tgt_pc : seq_pc;
  assign stall_o   = stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_q <= 1'b0;
    else         stall_q <= taken_o;
  end

  // R6
  stall_after_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |=> stall_o);
  // R6
  stall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);
  // R5
  no_spurious_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |=> !stall_o);
  // R7
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (!taken_o && next_pc_o == ((pc_i & ~PC_W'(1)) + PC_W'(2))));
  // R1
  uncond_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[INSTR_W-1 -: 5] == UNC_OP && !stall_o) |-> taken_o);
  // R8
  even_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_pc_o[0] == 1'b0);
endmodule

// File: tb/rbr_unit_bench.sv
`timescale 1ns/1ps
module rbr_unit_bench;
  localparam int MASK = 32'h1F_FFFF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr = '0;
  logic [20:0] pc = '0;
  logic        fn = 0, fv = 0, fz = 0, fc = 0;
  logic        taken;
  logic [20:0] next_pc;
  logic        stall;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit exp_stall = 0;
  bit exp_taken = 0;

  always #4 clk = ~clk;

  rbr_unit u_rbr_unit (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr), .pc_i(pc),
    .flag_n_i(fn), .flag_ov_i(fv), .flag_z_i(fz), .flag_c_i(fc),
    .taken_o(taken), .next_pc_o(next_pc), .stall_o(stall)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // behavioural model: inputs, plus the expected bubble bit from the previous step
  task automatic step(input logic [15:0] ins, input int pcv, input logic [3:0] nvzc,
                      input string tag);
    bit raw = 0;
    int woff = 0;
    int base, seqv, tgtv, exp_pc;
    bit fl;
    instr = ins; pc = pcv[20:0];
    {fn, fv, fz, fc} = nvzc;
    if (ins[15:11] == 5'b11010) begin
      raw  = 1;
      woff = ins[10] ? int'(ins[10:0]) - 2048 : int'(ins[10:0]);
    end else if (ins[15:11] == 5'b11100) begin
      woff = ins[7] ? int'(ins[7:0]) - 256 : int'(ins[7:0]);
      case (ins[10:9])
        2'd0: fl = nvzc[1];
        2'd1: fl = nvzc[0];
        2'd2: fl = nvzc[2];
        default: fl = nvzc[3];
      endcase
      raw = ins[8] ? !fl : fl;
    end
    exp_taken = raw && !exp_stall;
    base   = pcv & 32'h1F_FFFE;
    seqv   = (base + 2) & MASK;
    tgtv   = (base + 2 + 2 * woff) & MASK;
    exp_pc = exp_taken ? tgtv : seqv;
    @(negedge clk);
    chk(tag, "taken", int'(taken), int'(exp_taken));
    chk(tag, "next_pc", int'(next_pc), exp_pc);
    chk(tag, "stall", int'(stall), int'(exp_stall));
    @(posedge clk);
    exp_stall = exp_taken;
    #1;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R6 watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "stall_in_reset", int'(stall), 0);
    rst_ni = 1'b1;
    @(posedge clk); #1;

    // R1, R3 unconditional, positive/negative/extreme offsets; R6 bubble follows
    step(16'hD005, 32'h100, 4'b0000, "R1");
    step(16'h0000, 32'h10C, 4'b0000, "R6");
    step(16'h0000, 32'h10E, 4'b0000, "R6");
    step(16'hD400, 32'h800, 4'b1111, "R3");
    step(16'h0000, 32'h002, 4'b0000, "R6");
    step(16'hD3FF, 32'h2000, 4'b0000, "R3");
    step(16'h0000, 32'h2800, 4'b0000, "R6");

    // R2 each condition met, R4 each condition failed
    for (int k = 0; k < 8; k++) begin
      logic [3:0] met;
      logic [15:0] w;
      w = {5'b11100, k[2:0], (k[0] ? 8'h80 : 8'h7F)};
      case (k[2:1])
        2'd0: met = k[0] ? 4'b1101 : 4'b0010;
        2'd1: met = k[0] ? 4'b1110 : 4'b0001;
        2'd2: met = k[0] ? 4'b1011 : 4'b0100;
        default: met = k[0] ? 4'b0111 : 4'b1000;
      endcase
      step(w, 32'h4000 + 16 * k, met, "R2");
      step(16'h0000, 32'h5000, 4'b0000, "R6");
      step(w, 32'h6000 + 16 * k, ~met, "R4");
    end

    // R5 words outside both encodings, branch-friendly flags
    step(16'hD800, 32'h300, 4'b1111, "R5");
    step(16'hE800, 32'h302, 4'b1111, "R5");
    step(16'hF0FF, 32'h304, 4'b0000, "R5");
    step(16'hC005, 32'h306, 4'b1111, "R5");
    step(16'h0000, 32'h308, 4'b0000, "R5");

    // R10 wrap forward and backward
    step(16'hD001, 32'h1FFFFE, 4'b0000, "R10");
    step(16'h0000, 32'h000002, 4'b0000, "R6");
    step(16'hE2FE, 32'h000000, 4'b0001, "R10");
    step(16'h0000, 32'h1FFFFE, 4'b0000, "R6");

    // R8 odd pc ignored bit 0
    step(16'h0000, 32'h101, 4'b0000, "R8");
    step(16'hD002, 32'h203, 4'b0000, "R8");
    step(16'h0000, 32'h20A, 4'b0000, "R6");

    // R7 back-to-back taken branches: second is flushed, third taken again
    step(16'hD010, 32'h400, 4'b0000, "R7");
    step(16'hD010, 32'h422, 4'b0000, "R7");
    step(16'hE001, 32'h424, 4'b0010, "R7");
    step(16'hE101, 32'h428, 4'b0000, "R7");
    step(16'h0000, 32'h42C, 4'b0000, "R7");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule